// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns 32-bit addresses seen on an inbound PCI bus into host physical addresses. It has four programmable DMA windows. Each window has three registers: a bus base with enable and scatter-gather flags, a size mask with 1 MB granularity, and a translated base.

A request that falls inside a direct window is relocated by adding its offset within the window to the translated base. A request that falls inside a scatter-gather window is resolved through a small, fully associative cache of 8 KB page entries. A cache miss, or an entry marked invalid, is reported as a miss so that the surrounding logic can fetch the entry and install it through the fill port. Software empties the whole cache by writing the flush register.

The request path has one cycle of latency. Every request produces exactly one registered response on the following cycle.

Top module: `dmawin_xlate`

## Requirements
- R1: Register address is {kind[1:0], window[1:0]}. The kind values are 0 = window base, 1 = size mask, 2 = translated base and 3 = flush. Window base keeps bits 31:20, bit 1 (scatter-gather) and bit 0 (enable); all its other bits read 0. Size mask keeps bits 31:20 only. Translated base keeps all 32 bits. Flush reads as 0. reg_rdata shows the addressed register on the cycle after reg_rd.
- R2: A window whose enable bit is 0 never matches. A request matched by no window returns rsp_valid with rsp_hit = 0, rsp_miss = 0 and rsp_phys = 0.
- R3: Window w matches address A when (A ^ base_w) & ~(mask_w | 0xFFFFF) is zero. When several enabled windows match, the lowest-numbered one is used and reported on rsp_win.
- R4: In a direct window (scatter-gather bit 0), rsp_hit = 1 and rsp_phys = translated_base + (A & (mask | 0xFFFFF)). This is a 33-bit sum, and its carry lands in bit 32.
- R5: A page entry is 20 bits: bit 0 is the valid flag and bits 19:1 are the physical page frame (physical address >> 13). In a scatter-gather window, a cached entry tagged with A[31:13] whose valid flag is 1 gives rsp_hit = 1 and rsp_phys = {0, frame, A[12:0]}.
- R6: In a scatter-gather window, a lookup that finds no cached entry, or finds one with valid flag 0, gives rsp_miss = 1, rsp_hit = 0 and rsp_phys = 0. rsp_hit and rsp_miss are never both 1.
- R7: Any write to a flush register (kind 3, any window) invalidates all cache entries and returns the replacement pointer to slot 0. A fill in the same cycle is dropped.
- R8: The cache holds 8 entries, filled in round-robin order. The ninth distinct page filled after a flush or reset replaces the first.
- R9: A fill whose page is already cached overwrites that entry in place and does not advance the replacement pointer.
- R10: rsp_valid is 1 exactly on the cycle after a cycle with req_valid = 1. The response reflects the registers and cache as they stood on the request cycle.
- R11: After reset, all windows are disabled, all registers read 0, the cache is empty and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | {kind, window} register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | PCI bus address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation produced an address |
| rsp_miss | output | 1 | Scatter-gather entry absent or invalid |
| rsp_win | output | 2 | Window that matched |
| rsp_phys | output | 33 | Translated physical address |
| fill_en | input | 1 | Install a page entry |
| fill_page | input | 19 | Bus page number (bus address >> 13) of the entry |
| fill_pte | input | 20 | Page entry: frame in 19:1, valid in 0 |

## Verification
The checker enforces several rules on every cycle: the one-cycle request/response pairing, the mutual exclusion of hit and miss, the zero address on any response without a hit, the zero low field of mask readback, and the quiet outputs after reset. Other behaviour depends on history and can only be shown by the bench's scenarios. This covers the window priority and match arithmetic, direct-offset carries, which entries survive round-robin replacement, in-place refills, and the effect of a flush. The bench checks these against a reference model of the windows and the cache, using directed cases and seeded random traffic.

// File: rtl/dmawin_pkg.sv
package dmawin_pkg;
  parameter int ADDR_W  = 32;
  parameter int PAGE_SH = 13;
  parameter int GRAN_SH = 20;

  localparam int PA_W   = ADDR_W + 1;
  localparam int PFN_W  = ADDR_W - PAGE_SH;
  localparam int PAGE_W = ADDR_W - PAGE_SH;
  localparam int PTE_W  = PFN_W + 1;
  localparam logic [ADDR_W-1:0] GRAN_KEEP = {{(ADDR_W-GRAN_SH){1'b1}}, {GRAN_SH{1'b0}}};

  typedef enum logic [1:0] {
    K_BASE  = 2'd0,
    K_MASK  = 2'd1,
    K_XBASE = 2'd2,
    K_FLUSH = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic              en;
    logic              sg;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] xbase;
  } win_cfg_t;
endpackage

// File: rtl/dmawin_regs.sv
module dmawin_regs
  import dmawin_pkg::*;
#(
  parameter int NWIN   = 4,
  localparam int WSEL_W = $clog2(NWIN),
  localparam int RA_W   = WSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [RA_W-1:0]   addr,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output win_cfg_t          cfg [NWIN],
  output logic              flush
);
  reg_kind_e         kind;
  logic [WSEL_W-1:0] wsel;
  logic [ADDR_W-1:0] rd_mux;

  assign kind  = reg_kind_e'(addr[RA_W-1 -: 2]);
  assign wsel  = addr[WSEL_W-1:0];
  assign flush = wr && (kind == K_FLUSH);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[w] <= '0;
      end else if (wr && (wsel == WSEL_W'(w))) begin
        case (kind)
          K_BASE: begin
            cfg[w].base <= wdata & GRAN_KEEP;
            cfg[w].sg   <= wdata[1];
            cfg[w].en   <= wdata[0];
          end
          K_MASK:  cfg[w].mask  <= wdata & GRAN_KEEP;
          K_XBASE: cfg[w].xbase <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (kind)
      K_BASE:  rd_mux = cfg[wsel].base | {{(ADDR_W-2){1'b0}}, cfg[wsel].sg, cfg[wsel].en};
      K_MASK:  rd_mux = cfg[wsel].mask;
      K_XBASE: rd_mux = cfg[wsel].xbase;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/dmawin_match.sv
module dmawin_match
  import dmawin_pkg::*;
#(
  parameter int NWIN   = 4,
  localparam int WSEL_W = $clog2(NWIN)
) (
  input  logic [ADDR_W-1:0] addr,
  input  win_cfg_t          cfg [NWIN],
  output logic              any,
  output logic [WSEL_W-1:0] win,
  output logic              sg,
  output logic [PA_W-1:0]   direct_pa
);
  logic [NWIN-1:0]   hit;
  logic [ADDR_W-1:0] span [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    assign span[w] = cfg[w].mask | ~GRAN_KEEP;
    assign hit[w]  = cfg[w].en && (((addr ^ cfg[w].base) & ~span[w]) == '0);
  end

  always_comb begin
    win = '0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (hit[w]) win = WSEL_W'(w);
    end
  end

  assign any       = |hit;
  assign sg        = cfg[win].sg;
  assign direct_pa = {1'b0, cfg[win].xbase} + {1'b0, addr & span[win]};
endmodule

// File: rtl/dmawin_tcache.sv
module dmawin_tcache
  import dmawin_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [PAGE_W-1:0] lk_page,
  output logic              lk_hit,
  output logic [PTE_W-1:0]  lk_pte,
  input  logic              fill_en,
  input  logic [PAGE_W-1:0] fill_page,
  input  logic [PTE_W-1:0]  fill_pte
);
  logic [ENTRIES-1:0] vld;
  logic [PAGE_W-1:0]  tag [ENTRIES];
  logic [PTE_W-1:0]   pte [ENTRIES];
  logic [PTR_W-1:0]   ptr;
  logic [ENTRIES-1:0] lk_match, fl_match;
  logic               dup;
  logic [PTR_W-1:0]   dup_idx, wr_idx;
  logic               wr_en;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_tag
    assign lk_match[i] = vld[i] && (tag[i] == lk_page);
    assign fl_match[i] = vld[i] && (tag[i] == fill_page);
  end

  always_comb begin
    lk_pte  = '0;
    dup_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) lk_pte  = pte[i];
      if (fl_match[i]) dup_idx = PTR_W'(i);
    end
  end

  assign lk_hit = |lk_match;
  assign dup    = |fl_match;
  assign wr_en  = fill_en && !flush;
  assign wr_idx = dup ? dup_idx : ptr;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
      if (!dup) ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag[wr_idx] <= fill_page;
      pte[wr_idx] <= fill_pte;
    end
  end
endmodule

// File: rtl/dmawin_xlate.sv
module dmawin_xlate
  import dmawin_pkg::*;
#(
  parameter int NWIN    = 4,
  parameter int ENTRIES = 8,
  localparam int WSEL_W = $clog2(NWIN),
  localparam int RA_W   = WSEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [WSEL_W-1:0] rsp_win,
  output logic [PA_W-1:0]   rsp_phys,
  input  logic              fill_en,
  input  logic [PAGE_W-1:0] fill_page,
  input  logic [PTE_W-1:0]  fill_pte
);
  win_cfg_t          cfg [NWIN];
  logic              flush;
  logic              m_any, m_sg;
  logic [WSEL_W-1:0] m_win;
  logic [PA_W-1:0]   m_direct;
  logic              c_hit;
  logic [PTE_W-1:0]  c_pte;
  logic              pte_ok;
  logic [PA_W-1:0]   sg_pa;

  dmawin_regs #(.NWIN(NWIN)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .flush(flush)
  );

  dmawin_match #(.NWIN(NWIN)) u_match (
    .addr(req_addr), .cfg(cfg), .any(m_any), .win(m_win), .sg(m_sg),
    .direct_pa(m_direct)
  );

  dmawin_tcache #(.ENTRIES(ENTRIES)) u_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_page(req_addr[ADDR_W-1:PAGE_SH]), .lk_hit(c_hit), .lk_pte(c_pte),
    .fill_en(fill_en), .fill_page(fill_page), .fill_pte(fill_pte)
  );

  assign pte_ok = c_hit && c_pte[0];
  assign sg_pa  = {1'b0, c_pte[PTE_W-1:1], req_addr[PAGE_SH-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
      rsp_phys  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
      rsp_phys  <= '0;
      if (req_valid && m_any) begin
        rsp_win <= m_win;
        if (m_sg) begin
          rsp_hit  <= pte_ok;
          rsp_miss <= !pte_ok;
          rsp_phys <= pte_ok ? sg_pa : '0;
        end else begin
          rsp_hit  <= 1'b1;
          rsp_phys <= m_direct;
        end
      end
    end
  end
endmodule

// File: rtl/dmawin_xlate_chk.sv
module dmawin_xlate_chk
  import dmawin_pkg::*;
#(
  parameter int NWIN    = 4,
  localparam int WSEL_W = $clog2(NWIN),
  localparam int RA_W   = WSEL_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [RA_W-1:0]   reg_addr,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [PA_W-1:0]   rsp_phys
);
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R10
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R6
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && rsp_miss));
  // R10
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit || rsp_miss) |-> rsp_valid);
  // R6
  nohit_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_phys == '0));
  // R1
  mask_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr[RA_W-1 -: 2] == 2'd1) |=> (reg_rdata[GRAN_SH-1:0] == '0));
  // R11
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_hit && !rsp_miss && reg_rdata == '0));
endmodule

bind dmawin_xlate dmawin_xlate_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_phys(rsp_phys)
);

// File: tb/tb_dmawin_xlate.sv
`timescale 1ns/1ps
module tb_dmawin_xlate;
  logic        clk = 0, rst = 1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [1:0]  rsp_win;
  logic [32:0] rsp_phys;
  logic        fill_en = 0;
  logic [18:0] fill_page = 0;
  logic [19:0] fill_pte = 0;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dmawin_xlate dut (.*);

  // reference model
  logic [31:0] m_base [4], m_mask [4], m_xb [4];
  bit          m_en [4], m_sg [4];
  bit          c_vld [8];
  logic [18:0] c_tag [8];
  logic [19:0] c_pte [8];
  int          c_ptr;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 0; m_mask[i] = 0; m_xb[i] = 0; m_en[i] = 0; m_sg[i] = 0;
    end
    for (int i = 0; i < 8; i++) c_vld[i] = 0;
    c_ptr = 0;
  endtask

  task automatic wr_reg(int kind, int w, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = {kind[1:0], w[1:0]}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    case (kind)
      0: begin m_base[w] = d & 32'hFFF0_0000; m_sg[w] = d[1]; m_en[w] = d[0]; end
      1: m_mask[w] = d & 32'hFFF0_0000;
      2: m_xb[w] = d;
      default: begin
        for (int i = 0; i < 8; i++) c_vld[i] = 0;
        c_ptr = 0;
      end
    endcase
  endtask

  task automatic rd_chk(string r, int kind, int w);
    logic [31:0] e;
    case (kind)
      0: e = m_base[w] | {30'd0, m_sg[w], m_en[w]};
      1: e = m_mask[w];
      2: e = m_xb[w];
      default: e = 0;
    endcase
    @(negedge clk);
    reg_rd = 1; reg_addr = {kind[1:0], w[1:0]};
    @(negedge clk);
    reg_rd = 0;
    chk(r, {32'd0, reg_rdata}, {32'd0, e});
  endtask

  task automatic fill(logic [18:0] pg, logic [19:0] pte);
    int dup;
    @(negedge clk);
    fill_en = 1; fill_page = pg; fill_pte = pte;
    @(negedge clk);
    fill_en = 0;
    dup = -1;
    for (int i = 7; i >= 0; i--) if (c_vld[i] && c_tag[i] == pg) dup = i;
    if (dup >= 0) c_pte[dup] = pte;
    else begin
      c_vld[c_ptr] = 1; c_tag[c_ptr] = pg; c_pte[c_ptr] = pte;
      c_ptr = (c_ptr + 1) % 8;
    end
  endtask

  function automatic logic [63:0] predict(logic [31:0] a);
    bit found = 0; int w = 0; logic [31:0] span;
    bit got = 0; logic [19:0] p = 0;
    logic hit = 0, miss = 0; logic [32:0] pa = 0;
    for (int i = 0; i < 4; i++) begin
      if (!found && m_en[i] &&
          (((a ^ m_base[i]) & ~(m_mask[i] | 32'h000F_FFFF)) == 0)) begin
        found = 1; w = i;
      end
    end
    if (found) begin
      span = m_mask[w] | 32'h000F_FFFF;
      if (!m_sg[w]) begin
        hit = 1; pa = {1'b0, m_xb[w]} + {1'b0, a & span};
      end else begin
        for (int i = 7; i >= 0; i--)
          if (c_vld[i] && c_tag[i] == a[31:13]) begin got = 1; p = c_pte[i]; end
        if (got && p[0]) begin hit = 1; pa = {1'b0, p[19:1], a[12:0]}; end
        else miss = 1;
      end
    end
    return {27'd0, 1'b1, hit, miss, (found ? w[1:0] : 2'd0), pa};
  endfunction

  task automatic req_chk(string r, logic [31:0] a);
    logic [63:0] e;
    e = predict(a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(r, {27'd0, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_phys}, e);
  endtask

  function automatic logic [19:0] mk_pte(logic [31:0] pa, bit v);
    return {pa[31:13], v};
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 rsp_valid after reset", {63'd0, rsp_valid}, 0);
    rd_chk("R11 base reads 0", 0, 2);
    rd_chk("R11 xbase reads 0", 2, 3);
    req_chk("R11 no window enabled", 32'h8000_0000);

    // R1 register field retention
    wr_reg(0, 1, 32'h8000_0FFF);
    rd_chk("R1 base fields", 0, 1);
    wr_reg(1, 1, 32'h3FFF_FFFF);
    rd_chk("R1 mask fields", 1, 1);
    wr_reg(2, 1, 32'h1234_5678);
    rd_chk("R1 xbase full", 2, 1);
    rd_chk("R1 flush reads 0", 3, 1);

    // R2 disabled window
    wr_reg(0, 1, 32'h8000_0000);
    wr_reg(2, 1, 32'h0);
    req_chk("R2 disabled window ignored", 32'h8000_1000);

    // R4 direct windows
    wr_reg(0, 1, 32'h8000_0001);
    req_chk("R4 direct 2GB window", 32'h8012_3456);
    wr_reg(0, 2, 32'hC000_0001);
    wr_reg(1, 2, 32'h3FF0_0000);
    wr_reg(2, 2, 32'h4000_0000);
    req_chk("R4 direct 3GB window", 32'hC000_0010);
    req_chk("R4 top of window", 32'hFFFF_FFFC);
    wr_reg(2, 2, 32'hFFF0_0000);
    req_chk("R4 carry into bit 32", 32'hC020_0004);

    // R3 priority and mask
    wr_reg(0, 0, 32'h8000_0001);
    wr_reg(2, 0, 32'h1000_0000);
    req_chk("R3 lowest window wins", 32'h8000_0010);
    req_chk("R3 outside 1MB goes to win1", 32'h8010_0010);

    // R5/R6 scatter-gather at 8MB
    wr_reg(0, 3, 32'h0080_0003);
    wr_reg(1, 3, 32'h0070_0000);
    req_chk("R6 empty cache miss", 32'h0080_2010);
    fill(19'h00401, mk_pte(32'h1234_4000, 1));
    req_chk("R5 cached entry hit", 32'h0080_2010);
    fill(19'h00402, mk_pte(32'h5555_6000, 0));
    req_chk("R6 invalid entry miss", 32'h0080_4000);
    req_chk("R2 address outside all", 32'h0100_0000);

    // R9 refill in place; then R8 round robin
    wr_reg(3, 0, 0);
    for (int i = 0; i < 4; i++) fill(19'h400 + i, mk_pte(32'h1000_0000 + i * 32'h2000, 1));
    fill(19'h400, mk_pte(32'h7777_E000, 1));
    fill(19'h401, mk_pte(32'h6666_C000, 1));
    for (int i = 4; i < 8; i++) fill(19'h400 + i, mk_pte(32'h1000_0000 + i * 32'h2000, 1));
    req_chk("R9 refill new frame", 32'h0080_0123);
    req_chk("R9 no slot lost", 32'h0080_E000);
    fill(19'h408, mk_pte(32'h2000_0000, 1));
    req_chk("R8 ninth evicts first", 32'h0080_0000);
    req_chk("R8 second survives", 32'h0080_2000);
    req_chk("R8 ninth present", 32'h0081_0004);

    // R7 flush
    wr_reg(3, 2, 32'hFFFF_FFFF);
    req_chk("R7 flush clears", 32'h0080_2000);
    for (int i = 0; i < 8; i++) fill(19'h410 + i, mk_pte(32'h3000_0000 + i * 32'h2000, 1));
    req_chk("R7 pointer back to slot 0", 32'h0082_0000);
    req_chk("R7 last of eight", 32'h0082_E000);

    // random traffic, R3 R4 R5 R6 R8 R10
    for (int it = 0; it < 400; it++) begin
      int op; int w;
      op = $urandom_range(0, 9);
      w  = $urandom_range(0, 3);
      if (op == 0) begin
        wr_reg(0, w, ($urandom & 32'hFFF0_0000) | $urandom_range(0, 3));
      end else if (op == 1) begin
        wr_reg(1, w, ($urandom_range(0, 1) ? 32'h0070_0000 : ($urandom & 32'h0FF0_0000)));
      end else if (op == 2) begin
        wr_reg(2, w, $urandom);
      end else if (op == 3) begin
        fill(19'h400 + 19'($urandom_range(0, 20)), 20'($urandom));
      end else if (op == 4 && $urandom_range(0, 5) == 0) begin
        wr_reg(3, w, 0);
      end else begin
        logic [31:0] a;
        if ($urandom_range(0, 1)) a = m_base[w] | ($urandom & 32'h00FF_FFFF);
        else a = 32'h0080_0000 + ($urandom_range(0, 20) << 13) + $urandom_range(0, 8191);
        req_chk("R10 random request", a);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule